// File: doc/BRIEF.md
# Boot-Area Address Decoder with Remap

This block is the address decoder that sits in front of one master port of a bus matrix; every master gets its own copy. For each address offered with a valid strobe, it produces a one-hot select naming the slave that owns the address. If no slave owns it, it raises a decode-error flag instead. Most of the map is made of fixed windows. The lowest window, the boot area, is special: it can lead to one of three slaves.

Which slave answers in the boot area depends on two stored bits. The boot-mode bit is captured from a pin while reset is held. It chooses internal boot ROM or the external memory as the source of the first instructions. The remap bit is sticky and is set by a one-cycle command. While it is set, internal SRAM replaces the boot memory in the boot area, so software can rewrite its exception vectors. A clear input and reset both return the boot area to the boot memory. Decoding itself is combinational; only the two state bits are registered.

Top module: `boot_remap_decoder`

## Requirements
- R1: The select bit positions are: bit 0 internal boot ROM, bit 1 internal SRAM, bit 2 external memory, bit 3 peripheral bridge, bit 4 display/host window. The fixed windows are: ROM 0x1000_0000–0x1FFF_FFFF, SRAM 0x2000_0000–0x2FFF_FFFF, external 0x3000_0000–0x8FFF_FFFF, display/host 0x9000_0000–0x9FFF_FFFF, peripherals 0xF000_0000–0xFFFF_FFFF.
- R2: On every rising clock edge while `rst_n` is low, `boot_pin` is captured. With remap off, the boot area 0x0000_0000–0x0FFF_FFFF selects the ROM (bit 0) if the captured value is 1, and external memory (bit 2) if it is 0.
- R3: Changes of `boot_pin` while `rst_n` is high have no effect on any select.
- R4: A `remap_set` pulse sampled at a rising edge with `rst_n` high makes the boot area select SRAM (bit 1) from the next cycle on, until cleared.
- R5: `remap_clr` sampled high at a rising edge turns remap off. If `remap_set` is high in the same cycle, the clear wins.
- R6: A rising edge with `rst_n` low turns remap off.
- R7: The fixed ROM and SRAM windows select their own slave whatever the remap state.
- R8: A valid address in 0xA000_0000–0xEFFF_FFFF raises `dec_err` and selects no slave.
- R9: While `bus_valid` is low, `slv_sel` is all zero and `dec_err` is low.
- R10: While `bus_valid` is high, exactly one of the five select bits and `dec_err` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the boot pin is captured while low |
| bus_valid | input | 1 | Address strobe qualifying the decode |
| bus_addr | input | 32 | Address from the master |
| boot_pin | input | 1 | Boot-source strap: 1 internal ROM, 0 external memory |
| remap_set | input | 1 | One-cycle command: place SRAM at the boot area |
| remap_clr | input | 1 | Return the boot area to boot memory |
| slv_sel | output | 5 | One-hot slave select |
| dec_err | output | 1 | Valid address hit no window |

## Verification
The hardest case to reach from the ports is a boot-area access right after the remap state has been changed by a conflicting command. This covers a set and a clear in the same cycle, and a reset arriving while remap is on with the pin at a different value than at the previous reset. The stimulus puts these sequences in directed phases between long random stretches. In those stretches the address regions, remap pulses and pin toggles are drawn at random. Each cycle is compared against a behavioural model of the two state bits and the address map.

// File: rtl/bdec_pkg.sv
// Shared types and the fixed address map of the boot-area decoder.
// Assumes a 32-bit address and a boot area starting at address zero.
package bdec_pkg;

    localparam int ADDR_W    = 32;
    localparam int NUM_SLV   = 5;
    localparam int NUM_FIXED = 5;
    localparam int SEL_W     = $clog2(NUM_SLV);

    typedef enum logic [SEL_W-1:0] {
        SL_ROM    = 3'd0,
        SL_SRAM   = 3'd1,
        SL_EXT    = 3'd2,
        SL_PERIPH = 3'd3,
        SL_DISP   = 3'd4
    } slave_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] last;
        slave_e            target;
    } region_t;

    // Upper bound of the boot area (base is zero).
    localparam logic [ADDR_W-1:0] BOOT_LAST = 32'h0FFF_FFFF;

    // Fixed windows, each leading to exactly one slave.
    localparam region_t FIXED_MAP [NUM_FIXED] = '{
        '{base: 32'h1000_0000, last: 32'h1FFF_FFFF, target: SL_ROM},
        '{base: 32'h2000_0000, last: 32'h2FFF_FFFF, target: SL_SRAM},
        '{base: 32'h3000_0000, last: 32'h8FFF_FFFF, target: SL_EXT},
        '{base: 32'h9000_0000, last: 32'h9FFF_FFFF, target: SL_DISP},
        '{base: 32'hF000_0000, last: 32'hFFFF_FFFF, target: SL_PERIPH}
    };

endpackage

// File: rtl/bdec_state.sv
// Holds the two state bits that steer the boot area: the boot-source strap
// captured during reset and the sticky remap flag.
// Assumes boot_pin is static around reset release; clear has priority over set.
module bdec_state (
    input  logic clk,
    input  logic rst_n,
    input  logic boot_pin,
    input  logic remap_set,
    input  logic remap_clr,
    output logic boot_int,
    output logic remap_on
);

    logic strap_q;
    logic remap_q;

    // Capture the strap on every edge while reset is held, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= boot_pin;
        end
    end

    // Sticky remap flag: reset and clear drop it, a set command raises it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remap_q <= 1'b0;
        end else if (remap_clr) begin
            remap_q <= 1'b0;
        end else if (remap_set) begin
            remap_q <= 1'b1;
        end
    end

    assign boot_int = strap_q;
    assign remap_on = remap_q;

endmodule

// File: rtl/bdec_match.sv
// Compares the address against the boot area and every fixed window.
// Assumes the boot area starts at zero and the fixed windows do not overlap.
module bdec_match
    import bdec_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr,
    output logic                 boot_hit,
    output logic [NUM_FIXED-1:0] fixed_hit
);

    // Boot area test needs only the upper bound.
    assign boot_hit = (addr <= BOOT_LAST);

    // One range comparator per fixed window.
    for (genvar g = 0; g < NUM_FIXED; g++) begin : g_win
        assign fixed_hit[g] = (addr >= FIXED_MAP[g].base) &&
                              (addr <= FIXED_MAP[g].last);
    end

endmodule

// File: rtl/bdec_select.sv
// Turns window hits and boot state into a one-hot slave select or a
// decode error, qualified by the valid strobe.
// Assumes at most one window hit at a time.
module bdec_select
    import bdec_pkg::*;
(
    input  logic                 valid,
    input  logic                 boot_hit,
    input  logic [NUM_FIXED-1:0] fixed_hit,
    input  logic                 boot_int,
    input  logic                 remap_on,
    output logic [NUM_SLV-1:0]   slv_sel,
    output logic                 dec_err
);

    slave_e             boot_tgt;
    logic [NUM_SLV-1:0] sel_raw;

    // Choose which of the three slaves owns the boot area now.
    always_comb begin
        if (remap_on) begin
            boot_tgt = SL_SRAM;
        end else if (boot_int) begin
            boot_tgt = SL_ROM;
        end else begin
            boot_tgt = SL_EXT;
        end
    end

    // Gather hits into an unqualified select vector.
    always_comb begin
        sel_raw = '0;
        if (boot_hit) begin
            sel_raw[boot_tgt] = 1'b1;
        end
        for (int i = 0; i < NUM_FIXED; i++) begin
            if (fixed_hit[i]) begin
                sel_raw[FIXED_MAP[i].target] = 1'b1;
            end
        end
    end

    // Qualify with the strobe and flag misses.
    always_comb begin
        slv_sel = valid ? sel_raw : '0;
        dec_err = valid && (sel_raw == '0);
    end

endmodule

// File: rtl/boot_remap_decoder.sv
// Top of the per-master address decoder with a remappable boot area.
// Assumes one instance per master; decode is combinational, only the
// strap and remap bits are registered.
module boot_remap_decoder
    import bdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              boot_pin,
    input  logic              remap_set,
    input  logic              remap_clr,
    output logic [NUM_SLV-1:0] slv_sel,
    output logic              dec_err
);

    logic                 boot_int;
    logic                 remap_on;
    logic                 boot_hit;
    logic [NUM_FIXED-1:0] fixed_hit;

    bdec_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_pin  (boot_pin),
        .remap_set (remap_set),
        .remap_clr (remap_clr),
        .boot_int  (boot_int),
        .remap_on  (remap_on)
    );

    bdec_match u_match (
        .addr      (bus_addr),
        .boot_hit  (boot_hit),
        .fixed_hit (fixed_hit)
    );

    bdec_select u_select (
        .valid     (bus_valid),
        .boot_hit  (boot_hit),
        .fixed_hit (fixed_hit),
        .boot_int  (boot_int),
        .remap_on  (remap_on),
        .slv_sel   (slv_sel),
        .dec_err   (dec_err)
    );

endmodule

// File: rtl/bdec_chk.sv
// Port-level properties of the boot-area decoder, bound to the top.
module bdec_chk
    import bdec_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               boot_pin,
    input logic               remap_set,
    input logic               remap_clr,
    input logic [NUM_SLV-1:0] slv_sel,
    input logic               dec_err
);

    logic in_boot;
    logic in_hole;
    logic in_sram;
    assign in_boot = (bus_addr[31:28] == 4'h0);
    assign in_hole = (bus_addr[31:28] >= 4'hA) && (bus_addr[31:28] <= 4'hE);
    assign in_sram = (bus_addr[31:28] == 4'h2);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> (slv_sel == '0) && !dec_err); // R9

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> ($countones({slv_sel, dec_err}) == 1)); // R10

    AST_HOLE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && in_hole) |-> dec_err && (slv_sel == '0)); // R8

    AST_SRAM_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && in_sram) |-> (slv_sel == 5'b00010)); // R7

    AST_REMAP_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(remap_set) && !$past(remap_clr) && bus_valid && in_boot)
        |-> (slv_sel == 5'b00010)); // R4

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(remap_clr) && bus_valid && in_boot)
        |-> !slv_sel[1]); // R5

    AST_PIN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(remap_set) && !$past(remap_clr) &&
         $past(bus_valid) && $past(bus_addr[31:28]) == 4'h0 &&
         bus_valid && in_boot)
        |-> $stable(slv_sel)); // R3

endmodule

bind boot_remap_decoder bdec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .boot_pin  (boot_pin),
    .remap_set (remap_set),
    .remap_clr (remap_clr),
    .slv_sel   (slv_sel),
    .dec_err   (dec_err)
);

// File: tb/sim_boot_remap_decoder.sv
`timescale 1ns/1ps
module sim_boot_remap_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        boot_pin = 1'b1;
    logic        remap_set = 1'b0;
    logic        remap_clr = 1'b0;
    logic [4:0]  slv_sel;
    logic        dec_err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    bit m_strap;
    bit m_remap;

    always #2 clk = ~clk;  // 250 MHz

    boot_remap_decoder u0 (
        .clk (clk), .rst_n (rst_n), .bus_valid (bus_valid), .bus_addr (bus_addr),
        .boot_pin (boot_pin), .remap_set (remap_set), .remap_clr (remap_clr),
        .slv_sel (slv_sel), .dec_err (dec_err)
    );

    // expected select from the address map and model state (R1, R2, R4, R7, R8)
    function automatic logic [5:0] expect_out(bit v, logic [31:0] a);
        int n = int'(a[31:28]);
        logic [4:0] s = '0;
        if (!v) return 6'b0;
        if (n == 0) begin
            if (m_remap) s = 5'b00010;
            else if (m_strap) s = 5'b00001;
            else s = 5'b00100;
        end else if (n == 1) s = 5'b00001;
        else if (n == 2) s = 5'b00010;
        else if (n >= 3 && n <= 8) s = 5'b00100;
        else if (n == 9) s = 5'b10000;
        else if (n == 15) s = 5'b01000;
        return {s, (s == '0)};
    endfunction

    function automatic string tag_for(bit v, logic [31:0] a);
        int n = int'(a[31:28]);
        if (!v) return "R9";
        if (n >= 10 && n <= 14) return "R8";
        if (n == 0) return m_remap ? "R4" : "R2";
        if (n == 1 || n == 2) return "R7";
        return "R1";
    endfunction

    // one cycle: drive, compare, clock, update model
    task automatic cyc(bit v, logic [31:0] a, bit r, bit pin, bit set, bit clr, string tag);
        logic [5:0] exp_o;
        string t;
        @(negedge clk);
        bus_valid = v; bus_addr = a; rst_n = r; boot_pin = pin;
        remap_set = set; remap_clr = clr;
        #1;
        exp_o = expect_out(v, a);
        t = (tag == "") ? tag_for(v, a) : tag;
        total++;
        if ({slv_sel, dec_err} !== exp_o) begin
            bad++;
            $display("FAIL %s addr=%h sel/err actual=%b expected=%b", t, a, {slv_sel, dec_err}, exp_o);
        end
        total++;
        if (v && $countones({slv_sel, dec_err}) != 1) begin
            bad++;
            $display("FAIL R10 addr=%h actual=%b expected one bit set", a, {slv_sel, dec_err});
        end
        @(posedge clk);
        if (!r) begin m_strap = pin; m_remap = 0; end
        else if (clr) m_remap = 0;
        else if (set) m_remap = 1;
    endtask

    task automatic rand_phase(int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] a = $urandom;
            bit v = ($urandom % 4) != 0;
            bit s = ($urandom % 12) == 0;
            bit c = ($urandom % 16) == 0;
            bit p = $urandom % 2;   // R3: pin wanders while out of reset
            if ($urandom % 3 == 0) a[31:28] = 4'h0;
            cyc(v, a, 1, p, s, c, "");
        end
    endtask

    initial begin
        #40000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // prime: reset with strap = 1 (R2)
        @(negedge clk); rst_n = 0; boot_pin = 1;
        @(posedge clk); m_strap = 1; m_remap = 0;
        cyc(1, 32'h0000_0100, 0, 1, 0, 0, "R2");
        cyc(1, 32'h0000_0100, 1, 1, 0, 0, "R2");
        cyc(0, 32'h0000_0100, 1, 1, 0, 0, "R9");
        cyc(1, 32'h2000_0040, 1, 1, 0, 0, "R7");
        cyc(1, 32'hB000_0000, 1, 1, 0, 0, "R8");
        cyc(1, 32'hF000_1000, 1, 1, 0, 0, "R1");
        cyc(1, 32'h9000_0000, 1, 1, 0, 0, "R1");
        cyc(1, 32'h8FFF_FFFF, 1, 1, 0, 0, "R1");
        cyc(1, 32'h0FFF_FFFF, 1, 1, 0, 0, "R2");
        // R3: pin drops after reset, boot area stays on ROM
        cyc(1, 32'h0000_0000, 1, 0, 0, 0, "R3");
        cyc(1, 32'h0000_0004, 1, 0, 0, 0, "R3");
        // R4: remap, then boot area is SRAM; R7 ROM window still ROM
        cyc(1, 32'h0000_0004, 1, 0, 1, 0, "R4");
        cyc(1, 32'h0000_0004, 1, 0, 0, 0, "R4");
        cyc(1, 32'h1000_0000, 1, 0, 0, 0, "R7");
        cyc(1, 32'h2FFF_FFFC, 1, 0, 0, 0, "R7");
        // R5: set and clear together, clear wins
        cyc(1, 32'h0000_0008, 1, 0, 1, 1, "R5");
        cyc(1, 32'h0000_0008, 1, 0, 0, 0, "R5");
        cyc(1, 32'h0000_0008, 1, 0, 1, 0, "R4");
        cyc(1, 32'h0000_0008, 1, 0, 0, 1, "R5");
        cyc(1, 32'h0000_0008, 1, 0, 0, 0, "R5");
        rand_phase(600);
        // R6: remap on, then reset with strap 0 -> external memory
        cyc(1, 32'h0000_0010, 1, 1, 1, 0, "R4");
        cyc(1, 32'h0000_0010, 0, 0, 0, 0, "R6");
        cyc(1, 32'h0000_0010, 1, 0, 0, 0, "R6");
        cyc(1, 32'h0000_0010, 1, 1, 0, 0, "R3");
        rand_phase(600);
        // R6 again with strap 1
        cyc(1, 32'h0000_0020, 1, 0, 1, 0, "R4");
        cyc(1, 32'h0000_0020, 0, 1, 1, 0, "R6");
        cyc(1, 32'h0000_0020, 1, 0, 0, 0, "R6");
        rand_phase(400);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule